// File: doc/BRIEF.md
# Index-Prefixed Opcode Decoder

This block decodes the opcode byte that arrives after an index-register prefix in an 8-bit processor core. From that single byte it produces, with no clock involved, a control bundle: the operation class, the source and destination operand selects, the ALU function, which extra bytes the sequencer must still fetch (signed displacement, immediate byte, immediate word), the total T-state cost of the instruction, and the rule by which the internal memory-pointer register is updated. In these forms the index register's high and low bytes take the place of H and L in register-only operations, while memory operands are addressed by the index plus a signed displacement.

Opcodes that the index prefix does not alter are flagged for the unprefixed decoder, and the bit-operation sub-prefix is flagged for its own decoder. A small companion datapath, advanced by a clock enable, registers the effective address (index plus sign-extended displacement), the 16-bit sum of the index and a selected register pair, the flags of that addition, and the memory-pointer value for the rules it can compute locally.

Top module: `idx_prefix_unit`

## Requirements
- R1: An opcode the prefix does not alter gives passThru=1, opClass=16, tStates=0, all selects 15 and no fetch; this covers 0x76 and every 0x40-0xBF move or ALU form whose operand codes include none of 4, 5 or 6, and any other unlisted code.
- R2: Opcode 0xCB gives subHandoff=1, opClass=17, tStates=0 and passThru=0.
- R3: In a register-only move (opClass 1), INC/DEC (3/4) or ALU form (2), operand code 4 selects the index high byte (select 8) and code 5 the index low byte (select 9); such forms cost 8 T-states with ptrRule=0 (keep).
- R4: A form with operand code 6 selects memory (select 10), keeps codes 4 and 5 as the real H and L, sets needDisp, costs 19 T-states and sets ptrRule=2 (effective address); INC/DEC of memory (0x34/0x35) cost 23.
- R5: 0x26/0x2E load an immediate byte into an index half (select 11 as source, needImm8, 11 T); 0x36 stores an immediate byte to memory (needDisp and needImm8, 19 T, ptrRule=2); 0x21 loads an immediate word (needImm16, 14 T); 0x22/0x2A store/load the index at an absolute word address (needImm16, 20 T, ptrRule=3).
- R6: 0x09, 0x19, 0x29, 0x39 give opClass=5, 15 T-states and ptrRule=1, the added pair being chosen by opcode bits 5:4 (0 BC, 1 DE, 2 the index, 3 SP).
- R7: Fixed costs: 0x23/0x2B index increment/decrement 10, 0xE5 push 15, 0xE1 pop 14, 0xE3 stack exchange 23 with ptrRule=4, 0xE9 jump 8, 0xF9 copy to SP 10; 0x00, 0xDD and 0xFD are 8-T no-operations (opClass 0).
- R8: On an enabled clock, effAddr becomes the index plus the displacement byte sign-extended to 16 bits, modulo 2^16.
- R9: On an enabled clock, addFlags takes bit 0 = carry out of bit 15, bit 4 = carry out of bit 11, bit 1 = 0, bits 5 and 3 = sum bits 13 and 11, and bits 7, 6, 2 unchanged from flagsIn; addSum is the 16-bit sum.
- R10: On an enabled clock, ptrValue becomes old index + 1 when the opcode's ptrRule is 1, and the effective address otherwise.
- R11: With en low the registered outputs hold; a synchronous reset clears them to zero.
- R12: ALU forms give aluOp = opcode bits 5:3 (0 ADD ... 7 CP) with destination select 7 (A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Datapath clock enable |
| opcode | input | 8 | Byte following the index prefix |
| idxVal | input | 16 | Current index register |
| regBc | input | 16 | BC pair |
| regDe | input | 16 | DE pair |
| regSp | input | 16 | Stack pointer |
| disp | input | 8 | Displacement byte |
| flagsIn | input | 8 | Current flags |
| opClass | output | 5 | Operation class |
| srcSel | output | 4 | Source operand select |
| dstSel | output | 4 | Destination operand select |
| aluOp | output | 3 | ALU function |
| needDisp | output | 1 | Displacement byte must be fetched |
| needImm8 | output | 1 | Immediate byte must be fetched |
| needImm16 | output | 1 | Immediate word must be fetched |
| tStates | output | 5 | Total T-state cost |
| ptrRule | output | 3 | Memory-pointer update rule |
| passThru | output | 1 | Hand opcode to unprefixed decoder |
| subHandoff | output | 1 | Bit-operation sub-prefix seen |
| effAddr | output | 16 | Registered effective address |
| addSum | output | 16 | Registered index plus pair |
| addFlags | output | 8 | Registered flags of the 16-bit add |
| ptrValue | output | 16 | Registered memory-pointer value |

## Verification
The bench builds the block with its default widths, a 16-bit address and an 8-bit displacement, so the carry out of bit 15, the half-carry out of bit 11 and the wrap of the effective address past 0xFFFF and below zero are all reached with small directed values. The opcode table covers every class the decoder yields, including H/L in memory forms, index-half moves, and the pass-through and hand-off codes, and the directed part drives the datapath through negative displacements, flag corner sums and a held enable.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [4:0] {
    C_NOP = 5'd0, C_LD8 = 5'd1, C_ALU8 = 5'd2, C_INC8 = 5'd3, C_DEC8 = 5'd4,
    C_ADD16 = 5'd5, C_LDI_IMM = 5'd6, C_LDI_ABS = 5'd7, C_STI_ABS = 5'd8,
    C_INC16 = 5'd9, C_DEC16 = 5'd10, C_PUSH = 5'd11, C_POP = 5'd12,
    C_EXSP = 5'd13, C_JPIDX = 5'd14, C_LDSP = 5'd15, C_PASS = 5'd16,
    C_HANDOFF = 5'd17
  } op_class_t;

  typedef enum logic [2:0] {
    P_KEEP = 3'd0, P_IDX_INC = 3'd1, P_EFF = 3'd2, P_ABS_INC = 3'd3, P_STACK = 3'd4
  } ptr_rule_t;

  localparam logic [3:0] S_HALF_HI = 4'd8;
  localparam logic [3:0] S_HALF_LO = 4'd9;
  localparam logic [3:0] S_MEM     = 4'd10;
  localparam logic [3:0] S_IMM     = 4'd11;
  localparam logic [3:0] S_NONE    = 4'd15;
  localparam logic [3:0] S_ACC     = 4'd7;

  typedef struct packed {
    op_class_t opClass;
    logic [3:0] srcSel;
    logic [3:0] dstSel;
    logic [2:0] aluOp;
    logic needDisp;
    logic needImm8;
    logic needImm16;
    logic [4:0] tStates;
    ptr_rule_t ptrRule;
  } decode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] pairSel;
    logic ptrFromIdx;
  } dp_strobe_t;
endpackage

// File: rtl/idx_ctrl_dec.sv
module idx_ctrl_dec
  import idx_pkg::*;
(
  input  logic [7:0]  opcode,
  output decode_t     dec,
  output dp_strobe_t  strobe
);
  logic [2:0] hiCode;
  logic [2:0] loCode;
  logic hiHalf, loHalf;

  assign hiCode = opcode[5:3];
  assign loCode = opcode[2:0];
  assign hiHalf = (hiCode == 3'd4) || (hiCode == 3'd5);
  assign loHalf = (loCode == 3'd4) || (loCode == 3'd5);

  // register code to select; codes 4/5 become index halves unless memory form
  function automatic logic [3:0] mapSel(input logic [2:0] code, input logic memForm);
    if (!memForm && code == 3'd4) return S_HALF_HI;
    if (!memForm && code == 3'd5) return S_HALF_LO;
    return {1'b0, code};
  endfunction

  always_comb begin
    dec = '{opClass: C_PASS, srcSel: S_NONE, dstSel: S_NONE, aluOp: 3'd0,
            needDisp: 1'b0, needImm8: 1'b0, needImm16: 1'b0, tStates: 5'd0,
            ptrRule: P_KEEP};
    case (opcode[7:6])
      2'b00: begin
        case (opcode)
          8'h00: begin dec.opClass = C_NOP; dec.tStates = 5'd8; end
          8'h09, 8'h19, 8'h29, 8'h39: begin  // R6
            dec.opClass = C_ADD16; dec.tStates = 5'd15; dec.ptrRule = P_IDX_INC;
          end
          8'h21: begin dec.opClass = C_LDI_IMM; dec.needImm16 = 1'b1; dec.tStates = 5'd14; end
          8'h22: begin
            dec.opClass = C_STI_ABS; dec.needImm16 = 1'b1; dec.tStates = 5'd20; dec.ptrRule = P_ABS_INC;
          end
          8'h2A: begin
            dec.opClass = C_LDI_ABS; dec.needImm16 = 1'b1; dec.tStates = 5'd20; dec.ptrRule = P_ABS_INC;
          end
          8'h23: begin dec.opClass = C_INC16; dec.tStates = 5'd10; end
          8'h2B: begin dec.opClass = C_DEC16; dec.tStates = 5'd10; end
          8'h24, 8'h25, 8'h2C, 8'h2D: begin
            dec.opClass = opcode[0] ? C_DEC8 : C_INC8;
            dec.srcSel = mapSel(hiCode, 1'b0); dec.dstSel = mapSel(hiCode, 1'b0);
            dec.tStates = 5'd8;
          end
          8'h26, 8'h2E: begin
            dec.opClass = C_LD8; dec.srcSel = S_IMM; dec.dstSel = mapSel(hiCode, 1'b0);
            dec.needImm8 = 1'b1; dec.tStates = 5'd11;
          end
          8'h34, 8'h35: begin
            dec.opClass = opcode[0] ? C_DEC8 : C_INC8;
            dec.srcSel = S_MEM; dec.dstSel = S_MEM; dec.needDisp = 1'b1;
            dec.tStates = 5'd23; dec.ptrRule = P_EFF;
          end
          8'h36: begin
            dec.opClass = C_LD8; dec.srcSel = S_IMM; dec.dstSel = S_MEM;
            dec.needDisp = 1'b1; dec.needImm8 = 1'b1; dec.tStates = 5'd19; dec.ptrRule = P_EFF;
          end
          default: ;
        endcase
      end
      2'b01: begin
        if (hiCode == 3'd6 && loCode == 3'd6) begin
          // halt code: not altered by the prefix
        end else if (hiCode == 3'd6 || loCode == 3'd6) begin  // R4
          dec.opClass = C_LD8;
          dec.srcSel = (loCode == 3'd6) ? S_MEM : mapSel(loCode, 1'b1);
          dec.dstSel = (hiCode == 3'd6) ? S_MEM : mapSel(hiCode, 1'b1);
          dec.needDisp = 1'b1; dec.tStates = 5'd19; dec.ptrRule = P_EFF;
        end else if (hiHalf || loHalf) begin  // R3
          dec.opClass = C_LD8;
          dec.srcSel = mapSel(loCode, 1'b0); dec.dstSel = mapSel(hiCode, 1'b0);
          dec.tStates = 5'd8;
        end
      end
      2'b10: begin
        if (loCode == 3'd6) begin
          dec.opClass = C_ALU8; dec.aluOp = hiCode; dec.srcSel = S_MEM; dec.dstSel = S_ACC;
          dec.needDisp = 1'b1; dec.tStates = 5'd19; dec.ptrRule = P_EFF;
        end else if (loHalf) begin
          dec.opClass = C_ALU8; dec.aluOp = hiCode; dec.srcSel = mapSel(loCode, 1'b0);
          dec.dstSel = S_ACC; dec.tStates = 5'd8;
        end
      end
      default: begin
        case (opcode)
          8'hE1: begin dec.opClass = C_POP; dec.tStates = 5'd14; end
          8'hE3: begin dec.opClass = C_EXSP; dec.tStates = 5'd23; dec.ptrRule = P_STACK; end
          8'hE5: begin dec.opClass = C_PUSH; dec.tStates = 5'd15; end
          8'hE9: begin dec.opClass = C_JPIDX; dec.tStates = 5'd8; end
          8'hF9: begin dec.opClass = C_LDSP; dec.tStates = 5'd10; end
          8'hDD, 8'hFD: begin dec.opClass = C_NOP; dec.tStates = 5'd8; end
          8'hCB: dec.opClass = C_HANDOFF;
          default: ;
        endcase
      end
    endcase
  end

  assign strobe.pairSel    = opcode[5:4];
  assign strobe.ptrFromIdx = (dec.ptrRule == P_IDX_INC);
endmodule

// File: rtl/idx_addr_dp.sv
module idx_addr_dp
  import idx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  dp_strobe_t    strobe,
  input  logic [AW-1:0] idxVal,
  input  logic [AW-1:0] regBc,
  input  logic [AW-1:0] regDe,
  input  logic [AW-1:0] regSp,
  input  logic [DW-1:0] disp,
  input  logic [7:0]    flagsIn,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] addSum,
  output logic [7:0]    addFlags,
  output logic [AW-1:0] ptrValue
);
  localparam int LOW_W = AW - 4;   // half-carry boundary
  localparam int F5_BIT = AW - 3;
  localparam int F3_BIT = AW - 5;

  logic [AW-1:0] pairVal;
  logic [AW:0]   wideSum;
  logic [LOW_W:0] lowSum;
  logic [AW-1:0] eaNext;
  logic [7:0]    flagsNext;

  always_comb begin
    case (strobe.pairSel)
      2'd0:    pairVal = regBc;
      2'd1:    pairVal = regDe;
      2'd2:    pairVal = idxVal;
      default: pairVal = regSp;
    endcase
  end

  assign wideSum = {1'b0, idxVal} + {1'b0, pairVal};
  assign lowSum  = {1'b0, idxVal[LOW_W-1:0]} + {1'b0, pairVal[LOW_W-1:0]};
  assign eaNext  = idxVal + {{(AW-DW){disp[DW-1]}}, disp};

  always_comb begin
    flagsNext    = flagsIn;
    flagsNext[0] = wideSum[AW];
    flagsNext[1] = 1'b0;
    flagsNext[3] = wideSum[F3_BIT];
    flagsNext[4] = lowSum[LOW_W];
    flagsNext[5] = wideSum[F5_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      effAddr  <= '0;
      addSum   <= '0;
      addFlags <= '0;
      ptrValue <= '0;
    end else if (en) begin
      effAddr  <= eaNext;
      addSum   <= wideSum[AW-1:0];
      addFlags <= flagsNext;
      ptrValue <= strobe.ptrFromIdx ? idxVal + 1'b1 : eaNext;
    end
  end
endmodule

// File: rtl/idx_prefix_unit.sv
module idx_prefix_unit
  import idx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] idxVal,
  input  logic [AW-1:0] regBc,
  input  logic [AW-1:0] regDe,
  input  logic [AW-1:0] regSp,
  input  logic [DW-1:0] disp,
  input  logic [7:0]    flagsIn,
  output logic [4:0]    opClass,
  output logic [3:0]    srcSel,
  output logic [3:0]    dstSel,
  output logic [2:0]    aluOp,
  output logic          needDisp,
  output logic          needImm8,
  output logic          needImm16,
  output logic [4:0]    tStates,
  output logic [2:0]    ptrRule,
  output logic          passThru,
  output logic          subHandoff,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] addSum,
  output logic [7:0]    addFlags,
  output logic [AW-1:0] ptrValue
);
  decode_t    dec;
  dp_strobe_t strobe;

  idx_ctrl_dec u_ctrl (.opcode(opcode), .dec(dec), .strobe(strobe));

  idx_addr_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .en(en), .strobe(strobe),
    .idxVal(idxVal), .regBc(regBc), .regDe(regDe), .regSp(regSp),
    .disp(disp), .flagsIn(flagsIn),
    .effAddr(effAddr), .addSum(addSum), .addFlags(addFlags), .ptrValue(ptrValue)
  );

  assign opClass    = dec.opClass;
  assign srcSel     = dec.srcSel;
  assign dstSel     = dec.dstSel;
  assign aluOp      = dec.aluOp;
  assign needDisp   = dec.needDisp;
  assign needImm8   = dec.needImm8;
  assign needImm16  = dec.needImm16;
  assign tStates    = dec.tStates;
  assign ptrRule    = dec.ptrRule;
  assign passThru   = (dec.opClass == C_PASS);
  assign subHandoff = (dec.opClass == C_HANDOFF);
endmodule

// File: rtl/idx_prefix_chk.sv
module idx_prefix_chk #(
  parameter int AW = 16,
  parameter int DW = 8
)(
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [7:0]    opcode,
  input logic [AW-1:0] idxVal,
  input logic [DW-1:0] disp,
  input logic [7:0]    flagsIn,
  input logic [4:0]    opClass,
  input logic          needDisp,
  input logic [4:0]    tStates,
  input logic [2:0]    ptrRule,
  input logic          passThru,
  input logic          subHandoff,
  input logic [AW-1:0] effAddr,
  input logic [AW-1:0] addSum,
  input logic [7:0]    addFlags,
  input logic [AW-1:0] ptrValue
);
  p_pass_free_r1: assert property (@(posedge clk) disable iff (rst)
    passThru |-> (tStates == 5'd0 && !subHandoff && !needDisp));

  p_handoff_r2: assert property (@(posedge clk) disable iff (rst)
    subHandoff |-> (tStates == 5'd0 && !passThru));

  p_half_cost_r3: assert property (@(posedge clk) disable iff (rst)
    (opClass == 5'd2 && !needDisp) |-> tStates == 5'd8);

  p_disp_eff_r4: assert property (@(posedge clk) disable iff (rst)
    needDisp |-> (ptrRule == 3'd2 && tStates >= 5'd19));

  p_ea_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> effAddr == $past(idxVal) + {{(AW-DW){$past(disp[DW-1])}}, $past(disp)});

  p_flag_keep_r9: assert property (@(posedge clk) disable iff (rst)
    en |=> (!addFlags[1] && addFlags[7] == $past(flagsIn[7]) &&
            addFlags[6] == $past(flagsIn[6]) && addFlags[2] == $past(flagsIn[2])));

  p_ptr_idx_r10: assert property (@(posedge clk) disable iff (rst)
    (en && ptrRule == 3'd1) |=> ptrValue == $past(idxVal) + 1'b1);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(effAddr) && $stable(addSum) && $stable(addFlags) && $stable(ptrValue)));

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (effAddr == '0 && addSum == '0 && addFlags == 8'd0 && ptrValue == '0));
endmodule

bind idx_prefix_unit idx_prefix_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_idx_prefix_unit.sv
module sim_idx_prefix_unit;
  logic clk = 1'b0;
  logic rst, en;
  logic [7:0] opcode, disp, flagsIn;
  logic [15:0] idxVal, regBc, regDe, regSp;
  logic [4:0] opClass, tStates;
  logic [3:0] srcSel, dstSel;
  logic [2:0] aluOp, ptrRule;
  logic needDisp, needImm8, needImm16, passThru, subHandoff;
  logic [15:0] effAddr, addSum, ptrValue;
  logic [7:0] addFlags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  idx_prefix_unit u0 (.*);

  // {req[3:0], op[7:0], cls[4:0], src[3:0], dst[3:0], alu[2:0], disp/imm8/imm16, t[4:0], ptr[2:0], pass, hand}
  localparam int NV = 36;
  localparam logic [40:0] VEC [NV] = '{
    {4'd6, 8'h09, 5'd5, 4'hF, 4'hF, 3'd0, 3'b000, 5'd15, 3'd1, 2'b00},  // R6
    {4'd6, 8'h39, 5'd5, 4'hF, 4'hF, 3'd0, 3'b000, 5'd15, 3'd1, 2'b00},
    {4'd5, 8'h21, 5'd6, 4'hF, 4'hF, 3'd0, 3'b001, 5'd14, 3'd0, 2'b00},  // R5
    {4'd5, 8'h22, 5'd8, 4'hF, 4'hF, 3'd0, 3'b001, 5'd20, 3'd3, 2'b00},
    {4'd5, 8'h2A, 5'd7, 4'hF, 4'hF, 3'd0, 3'b001, 5'd20, 3'd3, 2'b00},
    {4'd5, 8'h2E, 5'd1, 4'd11, 4'd9, 3'd0, 3'b010, 5'd11, 3'd0, 2'b00},
    {4'd5, 8'h36, 5'd1, 4'd11, 4'd10, 3'd0, 3'b110, 5'd19, 3'd2, 2'b00},
    {4'd7, 8'h23, 5'd9, 4'hF, 4'hF, 3'd0, 3'b000, 5'd10, 3'd0, 2'b00},  // R7
    {4'd7, 8'h2B, 5'd10, 4'hF, 4'hF, 3'd0, 3'b000, 5'd10, 3'd0, 2'b00},
    {4'd3, 8'h24, 5'd3, 4'd8, 4'd8, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},   // R3
    {4'd3, 8'h2D, 5'd4, 4'd9, 4'd9, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd4, 8'h34, 5'd3, 4'd10, 4'd10, 3'd0, 3'b100, 5'd23, 3'd2, 2'b00}, // R4
    {4'd4, 8'h35, 5'd4, 4'd10, 4'd10, 3'd0, 3'b100, 5'd23, 3'd2, 2'b00},
    {4'd4, 8'h66, 5'd1, 4'd10, 4'd4, 3'd0, 3'b100, 5'd19, 3'd2, 2'b00},
    {4'd4, 8'h74, 5'd1, 4'd4, 4'd10, 3'd0, 3'b100, 5'd19, 3'd2, 2'b00},
    {4'd4, 8'h7E, 5'd1, 4'd10, 4'd7, 3'd0, 3'b100, 5'd19, 3'd2, 2'b00},
    {4'd3, 8'h65, 5'd1, 4'd9, 4'd8, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd3, 8'h7C, 5'd1, 4'd8, 4'd7, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd3, 8'h6F, 5'd1, 4'd7, 4'd9, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd12, 8'h86, 5'd2, 4'd10, 4'd7, 3'd0, 3'b100, 5'd19, 3'd2, 2'b00}, // R12
    {4'd12, 8'hBE, 5'd2, 4'd10, 4'd7, 3'd7, 3'b100, 5'd19, 3'd2, 2'b00},
    {4'd12, 8'h9D, 5'd2, 4'd9, 4'd7, 3'd3, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd12, 8'hA4, 5'd2, 4'd8, 4'd7, 3'd4, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd7, 8'hE3, 5'd13, 4'hF, 4'hF, 3'd0, 3'b000, 5'd23, 3'd4, 2'b00},
    {4'd7, 8'hE5, 5'd11, 4'hF, 4'hF, 3'd0, 3'b000, 5'd15, 3'd0, 2'b00},
    {4'd7, 8'hE1, 5'd12, 4'hF, 4'hF, 3'd0, 3'b000, 5'd14, 3'd0, 2'b00},
    {4'd7, 8'hE9, 5'd14, 4'hF, 4'hF, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd7, 8'hF9, 5'd15, 4'hF, 4'hF, 3'd0, 3'b000, 5'd10, 3'd0, 2'b00},
    {4'd7, 8'h00, 5'd0, 4'hF, 4'hF, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd7, 8'hDD, 5'd0, 4'hF, 4'hF, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd7, 8'hFD, 5'd0, 4'hF, 4'hF, 3'd0, 3'b000, 5'd8, 3'd0, 2'b00},
    {4'd2, 8'hCB, 5'd17, 4'hF, 4'hF, 3'd0, 3'b000, 5'd0, 3'd0, 2'b01}, // R2
    {4'd1, 8'h76, 5'd16, 4'hF, 4'hF, 3'd0, 3'b000, 5'd0, 3'd0, 2'b10}, // R1
    {4'd1, 8'h40, 5'd16, 4'hF, 4'hF, 3'd0, 3'b000, 5'd0, 3'd0, 2'b10},
    {4'd1, 8'h80, 5'd16, 4'hF, 4'hF, 3'd0, 3'b000, 5'd0, 3'd0, 2'b10},
    {4'd1, 8'h01, 5'd16, 4'hF, 4'hF, 3'd0, 3'b000, 5'd0, 3'd0, 2'b10}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one enabled clock of the datapath, sampled at the following negedge
  task automatic dpStep(input logic [7:0] op, input logic [15:0] idx, input logic [15:0] pair,
                        input logic [7:0] d, input logic [7:0] fl);
    @(negedge clk);
    opcode = op; idxVal = idx; disp = d; flagsIn = fl; en = 1'b1;
    regBc = pair; regDe = pair; regSp = pair;
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; opcode = 8'h00; disp = 8'h00; flagsIn = 8'h00;
    idxVal = 16'h0; regBc = 16'h0; regDe = 16'h0; regSp = 16'h0;
    repeat (3) @(negedge clk);
    check("R11 reset", {effAddr, addSum, addFlags, ptrValue}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      opcode = VEC[i][36:29];
      #1;
      check($sformatf("R%0d decode op %h", VEC[i][40:37], VEC[i][36:29]),
            {27'd0, opClass, srcSel, dstSel, aluOp, needDisp, needImm8, needImm16,
             tStates, ptrRule, passThru, subHandoff},
            {27'd0, VEC[i][28:0]});
    end

    // R8: wrap above 0xFFFF and below zero
    dpStep(8'h86, 16'hFFF0, 16'h0, 8'h20, 8'h00);
    check("R8 ea wrap up", effAddr, 16'h0010);
    check("R10 ptr = ea", ptrValue, 16'h0010);
    dpStep(8'h86, 16'h0010, 16'h0, 8'h80, 8'h00);
    check("R8 ea negative", effAddr, 16'hFF90);
    dpStep(8'h86, 16'h1000, 16'h0, 8'hFE, 8'h00);
    check("R8 ea minus two", effAddr, 16'h0FFE);

    // R9: half carry out of bit 11, flags 7/6/2 kept
    dpStep(8'h09, 16'h0FFF, 16'h0001, 8'h00, 8'hFF);
    check("R9 sum", addSum, 16'h1000);
    check("R9 flags half", addFlags, 8'hD4);
    check("R10 ptr idx+1", ptrValue, 16'h1000);
    dpStep(8'h39, 16'hF800, 16'h0900, 8'h00, 8'h00);
    check("R9 flags carry", addFlags, 8'h11);
    check("R9 sum wrap", addSum, 16'h0100);
    dpStep(8'h19, 16'h2800, 16'h0000, 8'h00, 8'h00);
    check("R9 flags 5/3", addFlags, 8'h28);
    // R6: pair select 2 adds the index to itself
    dpStep(8'h29, 16'h8000, 16'h1234, 8'h00, 8'h00);
    check("R6 index doubled", addSum, 16'h0000);
    check("R9 flags double", addFlags, 8'h01);
    check("R10 ptr after double", ptrValue, 16'h8001);

    // R11: enable low holds
    @(negedge clk);
    idxVal = 16'h5555; disp = 8'h11; flagsIn = 8'hAA; opcode = 8'h09; en = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 hold ea", effAddr, 16'h8000);
    check("R11 hold sum", addSum, 16'h0000);
    check("R11 hold ptr", ptrValue, 16'h8001);

    // R11: synchronous reset
    rst = 1'b1;
    @(negedge clk);
    check("R11 sync reset", {effAddr, addSum, addFlags, ptrValue}, 64'd0);
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule